// File: doc/BRIEF.md
# MAC Traffic Statistics and Interrupt Status Unit

This unit keeps the traffic statistics of one MAC port and turns notable events into interrupts. The transmit and receive datapaths give it a one-cycle completion strobe per frame, together with the frame length and a few classification flags. From these it advances ten saturating counters and raises status bits. Software reaches everything through a simple register read/write port. Each direction has one registered interrupt line, and per-bit masks gate which status bits reach it.

Counters stop at their all-ones value and hold there instead of wrapping. A counter also stands still while the enable of its direction is low. Reading a counter returns its value and clears it to zero. Status bits are write-one-to-clear. A separate force address per direction lets software set any status bit to exercise the interrupt path, and a read of the force address returns the live status.

Top module: `mac_stat_irq_unit`

## Requirements
- R1: While enabled, each `tx_done` adds 1 to the tx frame counter (0x40) and `tx_len` to the tx byte counter (0x48). Each `rx_done` adds 1 to the rx frame counter (0x50) and `rx_len` to the rx byte counter (0x58), whatever its flags. When the flags are set, the same `rx_done` also adds 1 to the dropped frame counter (0x60, `rx_drop`) and `rx_len` to the dropped byte counter (0x68, `rx_drop`). It adds 1 to the CRC error counter (0x70, `rx_crc_bad`), the pause counter (0x78, `rx_pause`), the broadcast counter (0x80, `rx_bcast`) and the multicast counter (0x88, `rx_mcast`).
- R2: A counter saturates at 2^CNT_W-1 and stays there until it is read.
- R3: A counter does not change while the enable of its direction is 0. Counters 0x40 and 0x48 belong to transmit and the rest to receive. A read still clears a counter while it is frozen.
- R4: A read (`reg_rd`) returns the addressed register on `reg_rdata` after the next clock edge. A counter read clears that counter. An event in the same cycle as the read leaves the counter at the event's increment.
- R5: An overflow status bit sets on the event that takes its counter from below the maximum to the maximum. It does not set again while the counter is held at the maximum, and it can recur after a read clears the counter. Tx status bit 1 belongs to the tx frame counter and bit 2 to the tx byte counter. Rx status bits 1 to 8 belong to the counters at 0x50 through 0x88, in address order.
- R6: Tx status bit 0 sets on every enabled `tx_done`. Rx status bit 0 sets on an enabled `rx_done` that has neither `rx_drop` nor `rx_crc_bad`.
- R7: Writing to a status address (tx 0x00, rx 0x18) clears each bit written as 1. A set event in the same cycle wins over the clear.
- R8: Writing to a force address (tx 0x10, rx 0x28) sets each bit written as 1, whatever the enables. Reading a force address returns the status.
- R9: Mask registers sit at tx 0x08 and rx 0x20. Each interrupt output equals, one cycle after the status, the OR of the status bits whose mask bit is 0. A mask bit of 1 suppresses its bit.
- R10: While a direction is disabled, its events set no status bit, and the status bits it already holds stay unchanged.
- R11: After reset, both masks are all ones (tx 0x7, rx 0x1FF), and status, counters, `reg_rdata` and both interrupts are 0.
- R12: Registers sit on an 8-byte stride. An access with `reg_addr[2:0]` not zero, or to an unmapped word such as 0x30, reads 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Transmit direction enable |
| rx_enable | input | 1 | Receive direction enable |
| tx_done | input | 1 | One-cycle strobe: a frame was sent |
| tx_len | input | LEN_W | Byte count of the sent frame |
| rx_done | input | 1 | One-cycle strobe: a frame was received |
| rx_len | input | LEN_W | Byte count of the received frame |
| rx_drop | input | 1 | Received frame was dropped |
| rx_crc_bad | input | 1 | Received frame had a CRC mismatch |
| rx_pause | input | 1 | Received frame was a pause frame |
| rx_bcast | input | 1 | Received frame was broadcast |
| rx_mcast | input | 1 | Received frame was multicast |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The assertions check four rules on every cycle. A counter at its maximum stays there unless it is read. A counter stands still while its direction is disabled. A counter read during a disabled period leaves zero. A disabled direction raises no new status bit unless forced. They also check that a fully masked direction drives its interrupt low. The bench scenarios are needed for the rest. These are the exact counter sums, the one-shot nature of the overflow bits and their recurrence after a read-clear, and set-over-clear priority. They also cover read-clear racing an increment, the one-cycle interrupt latency, and the harmlessness of misaligned and unmapped accesses. A reference model in the bench predicts all of these under random traffic.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
  localparam int NUM_CNT = 10;
  localparam int TX_SW   = 3;
  localparam int RX_SW   = 9;
  localparam int DATA_W  = 32;

  // counter slots; 0..1 transmit, 2..9 receive
  localparam int C_TX_FRM   = 0;
  localparam int C_TX_BYT   = 1;
  localparam int C_RX_FRM   = 2;
  localparam int C_RX_BYT   = 3;
  localparam int C_DROP_FRM = 4;
  localparam int C_DROP_BYT = 5;
  localparam int C_CRC      = 6;
  localparam int C_PAUSE    = 7;
  localparam int C_BCAST    = 8;
  localparam int C_MCAST    = 9;
  localparam int NUM_TX_CNT = 2;

  // word indices (byte address / 8)
  localparam int W_TX_STAT  = 0;
  localparam int W_TX_MASK  = 1;
  localparam int W_TX_FORCE = 2;
  localparam int W_RX_STAT  = 3;
  localparam int W_RX_MASK  = 4;
  localparam int W_RX_FORCE = 5;
  localparam int W_CNT_BASE = 8;

  function automatic bool_t_dummy(input int x);
    return x;
  endfunction
endpackage

// File: rtl/mac_sat_counter.sv
module mac_sat_counter #(
  parameter int W     = 32,
  parameter int INC_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             evt,
  input  logic [INC_W-1:0] inc,
  input  logic             rd_clr,
  output logic [W-1:0]     value,
  output logic             sat_hit
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  function automatic logic [W-1:0] sat_add(input logic [W-1:0] a, input logic [INC_W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + (W+1)'(b);
    return s[W] ? MAXV : s[W-1:0];
  endfunction

  logic         live;
  logic [W-1:0] base;
  logic [W-1:0] nxt;

  assign live    = cnt_en & evt;
  assign base    = rd_clr ? '0 : value;
  assign nxt     = sat_add(base, inc);
  assign sat_hit = live & (nxt == MAXV) & (base != MAXV);

  always_ff @(posedge clk) begin
    if (!rst_n)      value <= '0;
    else if (live)   value <= nxt;
    else if (rd_clr) value <= '0;
  end
endmodule

// File: rtl/mac_status_bank.sv
module mac_status_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic         clr_wr,
  input  logic         force_wr,
  input  logic         mask_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] stat,
  output logic [N-1:0] mask,
  output logic         irq
);
  function automatic logic [N-1:0] next_stat(input logic [N-1:0] cur, input logic [N-1:0] setv,
                                             input logic [N-1:0] clrv, input logic [N-1:0] frcv);
    return (cur & ~clrv) | setv | frcv;
  endfunction

  logic [N-1:0] clr_bits;
  logic [N-1:0] frc_bits;

  assign clr_bits = clr_wr   ? wdata : '0;
  assign frc_bits = force_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '1;
      irq  <= 1'b0;
    end else begin
      stat <= next_stat(stat, set_evt, clr_bits, frc_bits);
      if (mask_wr) mask <= wdata;
      irq  <= |(stat & ~mask);
    end
  end
endmodule

// File: rtl/mac_stat_irq_unit.sv
module mac_stat_irq_unit
  import mac_stat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 14,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic              rx_enable,
  input  logic              tx_done,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic              rx_done,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              rx_drop,
  input  logic              rx_crc_bad,
  input  logic              rx_pause,
  input  logic              rx_bcast,
  input  logic              rx_mcast,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              tx_irq,
  output logic              rx_irq
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  // decode
  logic addr_ok;
  int   sel;
  assign addr_ok = (reg_addr[2:0] == 3'b000);
  always_comb sel = int'(reg_addr[ADDR_W-1:3]);

  logic tx_clr_wr, tx_force_wr, tx_mask_wr;
  logic rx_clr_wr, rx_force_wr, rx_mask_wr;
  assign tx_clr_wr   = reg_wr && addr_ok && (sel == W_TX_STAT);
  assign tx_mask_wr  = reg_wr && addr_ok && (sel == W_TX_MASK);
  assign tx_force_wr = reg_wr && addr_ok && (sel == W_TX_FORCE);
  assign rx_clr_wr   = reg_wr && addr_ok && (sel == W_RX_STAT);
  assign rx_mask_wr  = reg_wr && addr_ok && (sel == W_RX_MASK);
  assign rx_force_wr = reg_wr && addr_ok && (sel == W_RX_FORCE);

  // counter events
  logic             cnt_evt [NUM_CNT];
  logic [LEN_W-1:0] cnt_inc [NUM_CNT];
  logic             cnt_clr [NUM_CNT];
  logic [CNT_W-1:0] cnt_val [NUM_CNT];
  logic [NUM_CNT-1:0] cnt_hit;

  always_comb begin
    cnt_evt[C_TX_FRM]   = tx_done;               cnt_inc[C_TX_FRM]   = ONE;
    cnt_evt[C_TX_BYT]   = tx_done;               cnt_inc[C_TX_BYT]   = tx_len;
    cnt_evt[C_RX_FRM]   = rx_done;               cnt_inc[C_RX_FRM]   = ONE;
    cnt_evt[C_RX_BYT]   = rx_done;               cnt_inc[C_RX_BYT]   = rx_len;
    cnt_evt[C_DROP_FRM] = rx_done & rx_drop;     cnt_inc[C_DROP_FRM] = ONE;
    cnt_evt[C_DROP_BYT] = rx_done & rx_drop;     cnt_inc[C_DROP_BYT] = rx_len;
    cnt_evt[C_CRC]      = rx_done & rx_crc_bad;  cnt_inc[C_CRC]      = ONE;
    cnt_evt[C_PAUSE]    = rx_done & rx_pause;    cnt_inc[C_PAUSE]    = ONE;
    cnt_evt[C_BCAST]    = rx_done & rx_bcast;    cnt_inc[C_BCAST]    = ONE;
    cnt_evt[C_MCAST]    = rx_done & rx_mcast;    cnt_inc[C_MCAST]    = ONE;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam bit IS_TX = (i < NUM_TX_CNT);
    assign cnt_clr[i] = reg_rd && addr_ok && (sel == W_CNT_BASE + i);
    mac_sat_counter #(.W(CNT_W), .INC_W(LEN_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_en  (IS_TX ? tx_enable : rx_enable),
      .evt     (cnt_evt[i]),
      .inc     (cnt_inc[i]),
      .rd_clr  (cnt_clr[i]),
      .value   (cnt_val[i]),
      .sat_hit (cnt_hit[i])
    );
  end

  // status set events
  logic             tx_frame_evt, rx_frame_evt;
  logic [TX_SW-1:0] tx_set;
  logic [RX_SW-1:0] rx_set;
  assign tx_frame_evt = tx_enable & tx_done;
  assign rx_frame_evt = rx_enable & rx_done & ~rx_drop & ~rx_crc_bad;
  assign tx_set = {cnt_hit[NUM_TX_CNT-1:0], tx_frame_evt};
  assign rx_set = {cnt_hit[NUM_CNT-1:NUM_TX_CNT], rx_frame_evt};

  logic [TX_SW-1:0] tx_stat, tx_mask;
  logic [RX_SW-1:0] rx_stat, rx_mask;

  mac_status_bank #(.N(TX_SW)) u_tx_bank (
    .clk(clk), .rst_n(rst_n), .set_evt(tx_set),
    .clr_wr(tx_clr_wr), .force_wr(tx_force_wr), .mask_wr(tx_mask_wr),
    .wdata(reg_wdata[TX_SW-1:0]), .stat(tx_stat), .mask(tx_mask), .irq(tx_irq)
  );

  mac_status_bank #(.N(RX_SW)) u_rx_bank (
    .clk(clk), .rst_n(rst_n), .set_evt(rx_set),
    .clr_wr(rx_clr_wr), .force_wr(rx_force_wr), .mask_wr(rx_mask_wr),
    .wdata(reg_wdata[RX_SW-1:0]), .stat(rx_stat), .mask(rx_mask), .irq(rx_irq)
  );

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[DATA_W-1:RX_SW];

  // read path
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (addr_ok) begin
      case (sel)
        W_TX_STAT, W_TX_FORCE: rd_mux = DATA_W'(tx_stat);
        W_TX_MASK:             rd_mux = DATA_W'(tx_mask);
        W_RX_STAT, W_RX_FORCE: rd_mux = DATA_W'(rx_stat);
        W_RX_MASK:             rd_mux = DATA_W'(rx_mask);
        default: begin
          for (int i = 0; i < NUM_CNT; i++)
            if (sel == W_CNT_BASE + i) rd_mux = DATA_W'(cnt_val[i]);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/mac_stat_irq_chk.sv
module mac_stat_irq_chk
  import mac_stat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_enable,
  input logic             rx_enable,
  input logic [CNT_W-1:0] cnt_val [NUM_CNT],
  input logic             cnt_clr [NUM_CNT],
  input logic [TX_SW-1:0] tx_stat,
  input logic [TX_SW-1:0] tx_mask,
  input logic [RX_SW-1:0] rx_stat,
  input logic [RX_SW-1:0] rx_mask,
  input logic             tx_force_wr,
  input logic             rx_force_wr,
  input logic             tx_irq,
  input logic             rx_irq
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_c
    logic en_i;
    assign en_i = (i < NUM_TX_CNT) ? tx_enable : rx_enable;

    AST_CNT_HOLDS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_val[i] == MAXV && !cnt_clr[i]) |=> (cnt_val[i] == MAXV)); // R2

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !cnt_clr[i]) |=> $stable(cnt_val[i])); // R3

    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_clr[i] && !en_i) |=> (cnt_val[i] == '0)); // R4
  end

  AST_TX_NO_NEW_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enable && !tx_force_wr) |=> ((tx_stat & ~$past(tx_stat)) == '0)); // R10

  AST_RX_NO_NEW_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_enable && !rx_force_wr) |=> ((rx_stat & ~$past(rx_stat)) == '0)); // R10

  AST_TX_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&tx_mask) |=> !tx_irq); // R9

  AST_RX_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&rx_mask) |=> !rx_irq); // R9
endmodule

bind mac_stat_irq_unit mac_stat_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .rx_enable(rx_enable),
  .cnt_val(cnt_val), .cnt_clr(cnt_clr),
  .tx_stat(tx_stat), .tx_mask(tx_mask), .rx_stat(rx_stat), .rx_mask(rx_mask),
  .tx_force_wr(tx_force_wr), .rx_force_wr(rx_force_wr),
  .tx_irq(tx_irq), .rx_irq(rx_irq)
);

// File: tb/tb_mac_stat_irq_unit.sv
module tb_mac_stat_irq_unit;
  localparam int CW = 10;
  localparam int LW = 8;
  localparam int AW = 8;
  localparam int NC = 10;
  localparam longint MAXV = (longint'(1) << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_enable = 0, rx_enable = 0, tx_done = 0, rx_done = 0;
  logic [LW-1:0] tx_len = '0, rx_len = '0;
  logic rx_drop = 0, rx_crc_bad = 0, rx_pause = 0, rx_bcast = 0, rx_mcast = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic tx_irq, rx_irq;

  mac_stat_irq_unit #(.CNT_W(CW), .LEN_W(LW), .ADDR_W(AW)) dut (.*);

  always #10 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  // stimulus for the next cycle
  logic s_te = 0, s_re = 0, s_td = 0, s_rxd = 0;
  logic [LW-1:0] s_tl = '0, s_rl = '0;
  logic s_drop = 0, s_crc = 0, s_pau = 0, s_bc = 0, s_mc = 0;
  logic s_wr = 0, s_rdreg = 0;
  logic [AW-1:0] s_addr = '0;
  logic [31:0] s_wd = '0;

  // reference model
  longint m_cnt [NC];
  logic [2:0] m_txs, m_txm;
  logic [8:0] m_rxs, m_rxm;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] cnt_addr(input int i);
    return AW'(8'h40 + 8 * i);
  endfunction

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    case (a)
      8'h00, 8'h10: return 32'(m_txs);
      8'h08:        return 32'(m_txm);
      8'h18, 8'h28: return 32'(m_rxs);
      8'h20:        return 32'(m_rxm);
      default: begin
        for (int i = 0; i < NC; i++) if (a == cnt_addr(i)) return 32'(m_cnt[i]);
        return 32'h0;
      end
    endcase
  endfunction

  function automatic string tag_for(input logic [AW-1:0] a);
    if (a >= 8'h40) return "R4";
    if (a == 8'h30) return "R12";
    return "R8";
  endfunction

  task automatic cycle(input string tag);
    logic [31:0] exp_rd;
    logic exp_ti, exp_ri;
    logic [NC-1:0] hits;
    logic [2:0] tset;
    logic [8:0] rset;
    tx_enable = s_te; rx_enable = s_re; tx_done = s_td; tx_len = s_tl;
    rx_done = s_rxd; rx_len = s_rl; rx_drop = s_drop; rx_crc_bad = s_crc;
    rx_pause = s_pau; rx_bcast = s_bc; rx_mcast = s_mc;
    reg_wr = s_wr; reg_rd = s_rdreg; reg_addr = s_addr; reg_wdata = s_wd;
    exp_ti = |(m_txs & ~m_txm);
    exp_ri = |(m_rxs & ~m_rxm);
    exp_rd = model_read(s_addr);
    for (int i = 0; i < NC; i++) begin
      bit en, ev;
      longint inc, base, nxt;
      en = (i < 2) ? s_te : s_re;
      case (i)
        0: begin ev = s_td; inc = 1; end
        1: begin ev = s_td; inc = s_tl; end
        2: begin ev = s_rxd; inc = 1; end
        3: begin ev = s_rxd; inc = s_rl; end
        4: begin ev = s_rxd && s_drop; inc = 1; end
        5: begin ev = s_rxd && s_drop; inc = s_rl; end
        6: begin ev = s_rxd && s_crc; inc = 1; end
        7: begin ev = s_rxd && s_pau; inc = 1; end
        8: begin ev = s_rxd && s_bc; inc = 1; end
        default: begin ev = s_rxd && s_mc; inc = 1; end
      endcase
      base = (s_rdreg && s_addr == cnt_addr(i)) ? 0 : m_cnt[i];
      hits[i] = 1'b0;
      if (en && ev) begin
        nxt = (base + inc > MAXV) ? MAXV : base + inc;
        hits[i] = (nxt == MAXV) && (base != MAXV);
        m_cnt[i] = nxt;
      end else m_cnt[i] = base;
    end
    tset = {hits[1], hits[0], s_te & s_td};
    rset = {hits[9:2], s_re & s_rxd & ~s_drop & ~s_crc};
    m_txs = (m_txs & ~((s_wr && s_addr == 8'h00) ? s_wd[2:0] : 3'b0)) | tset
          | ((s_wr && s_addr == 8'h10) ? s_wd[2:0] : 3'b0);
    m_rxs = (m_rxs & ~((s_wr && s_addr == 8'h18) ? s_wd[8:0] : 9'b0)) | rset
          | ((s_wr && s_addr == 8'h28) ? s_wd[8:0] : 9'b0);
    if (s_wr && s_addr == 8'h08) m_txm = s_wd[2:0];
    if (s_wr && s_addr == 8'h20) m_rxm = s_wd[8:0];
    @(posedge clk);
    @(negedge clk);
    if (s_rdreg) chk(reg_rdata == exp_rd, tag, reg_rdata, exp_rd);
    chk(tx_irq == exp_ti, "R9 tx_irq", 32'(tx_irq), 32'(exp_ti));
    chk(rx_irq == exp_ri, "R9 rx_irq", 32'(rx_irq), 32'(exp_ri));
    s_td = 0; s_rxd = 0; s_drop = 0; s_crc = 0; s_pau = 0; s_bc = 0; s_mc = 0;
    s_wr = 0; s_rdreg = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    s_rdreg = 1; s_addr = a; cycle(tag);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    s_wr = 1; s_addr = a; s_wd = d; cycle(tag);
  endtask
  task automatic txf(input int len);
    s_td = 1; s_tl = LW'(len); cycle("R1");
  endtask
  task automatic rxf(input int len, input logic [4:0] fl);
    s_rxd = 1; s_rl = LW'(len);
    {s_mc, s_bc, s_pau, s_crc, s_drop} = fl;
    cycle("R1");
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NC; i++) m_cnt[i] = 0;
    m_txs = '0; m_rxs = '0; m_txm = '1; m_rxm = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk(reg_rdata == 0 && !tx_irq && !rx_irq, "R11", reg_rdata, 0);
    rd(8'h08, "R11");
    chk(reg_rdata == 32'h7, "R11 tx mask", reg_rdata, 32'h7);
    rd(8'h20, "R11");
    chk(reg_rdata == 32'h1FF, "R11 rx mask", reg_rdata, 32'h1FF);
    rd(8'h00, "R11");
    rd(8'h58, "R11");

    // R1 / R6 counting
    s_te = 1; s_re = 1;
    txf(100); txf(23);
    rxf(60, 5'b00000); rxf(70, 5'b00001); rxf(80, 5'b00010);
    rxf(90, 5'b11100);
    rd(8'h48, "R1");
    chk(reg_rdata == 123, "R1 tx bytes", reg_rdata, 123);
    rd(8'h58, "R1");
    chk(reg_rdata == 300, "R1 rx bytes", reg_rdata, 300);
    rd(8'h68, "R1"); rd(8'h70, "R1"); rd(8'h78, "R1"); rd(8'h80, "R1"); rd(8'h88, "R1");
    rd(8'h00, "R6");
    chk(reg_rdata[0] == 1'b1, "R6 tx frame bit", reg_rdata, 1);
    rd(8'h18, "R6");

    // R3 freeze
    txf(30); rd(8'h40, "R3"); rd(8'h48, "R3");
    s_te = 0; txf(50); txf(50);
    rd(8'h48, "R3");
    chk(reg_rdata == 0, "R3 frozen bytes", reg_rdata, 0);

    // R10 no new status while disabled, existing kept
    wr(8'h00, 32'h7, "R7");
    wr(8'h10, 32'h2, "R8");
    txf(10);
    rd(8'h00, "R10");
    chk(reg_rdata == 32'h2, "R10 tx status", reg_rdata, 32'h2);
    s_te = 1;

    // R8 force / mirror read
    wr(8'h28, 32'h1A0, "R8");
    rd(8'h28, "R8"); rd(8'h18, "R8");

    // R7 clear, and set wins over clear
    wr(8'h18, 32'h020, "R7"); rd(8'h18, "R7");
    s_rxd = 1; s_rl = 8'd64; s_wr = 1; s_addr = 8'h18; s_wd = 32'h1FF; cycle("R7");
    rd(8'h18, "R7");
    chk(reg_rdata == 32'h1, "R7 set wins", reg_rdata, 32'h1);

    // R9 masking
    wr(8'h20, 32'h0, "R9"); cycle("R9"); cycle("R9");
    chk(rx_irq == 1'b1, "R9 unmasked", 32'(rx_irq), 1);
    wr(8'h20, 32'h1FF, "R9"); cycle("R9"); cycle("R9");
    chk(rx_irq == 1'b0, "R9 masked", 32'(rx_irq), 0);

    // R4 read racing an event
    rd(8'h40, "R4");
    s_td = 1; s_tl = 8'd5; s_rdreg = 1; s_addr = 8'h40; cycle("R4");
    rd(8'h40, "R4");
    chk(reg_rdata == 1, "R4 race", reg_rdata, 1);

    // R2 / R5 saturation and recurrence
    wr(8'h00, 32'h7, "R7"); rd(8'h48, "R4");
    for (int k = 0; k < 5; k++) txf(255);
    rd(8'h00, "R5");
    chk(reg_rdata[2] == 1'b1, "R5 byte ovf", reg_rdata, 32'h4);
    wr(8'h00, 32'h4, "R7");
    txf(255);
    rd(8'h00, "R5");
    chk(reg_rdata[2] == 1'b0, "R5 no repeat while held", reg_rdata, 0);
    rd(8'h48, "R2");
    chk(reg_rdata == 32'(MAXV), "R2 saturated", reg_rdata, 32'(MAXV));
    for (int k = 0; k < 5; k++) txf(255);
    rd(8'h00, "R5");
    chk(reg_rdata[2] == 1'b1, "R5 recur", reg_rdata, 32'h4);

    // R12 misaligned / unmapped
    rd(8'h30, "R12");
    chk(reg_rdata == 0, "R12 unmapped", reg_rdata, 0);
    s_rdreg = 1; s_addr = 8'h44; cycle("R12");
    chk(reg_rdata == 0, "R12 misaligned", reg_rdata, 0);
    rd(8'h40, "R12");

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int op, n;
      if ($urandom % 64 == 0) s_te = ~s_te;
      if ($urandom % 64 == 0) s_re = ~s_re;
      s_td = ($urandom % 3 == 0); s_tl = LW'($urandom);
      s_rxd = ($urandom % 2 == 0); s_rl = LW'($urandom);
      {s_mc, s_bc, s_pau, s_crc, s_drop} = 5'($urandom) & 5'($urandom);
      op = $urandom % 10;
      n  = $urandom % 17;
      s_addr = (n < 6) ? AW'(8 * n) : (n < 16) ? cnt_addr(n - 6) : 8'h30;
      if (op < 3) s_rdreg = 1;
      else if (op == 3) begin s_wr = 1; s_wd = $urandom; end
      cycle(tag_for(s_addr));
    end
    s_te = 1; s_re = 1;
    for (int i = 0; i < NC; i++) rd(cnt_addr(i), "R4");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule